// File: doc/BRIEF.md
# Indexed Color Palette with Sequential Loader

This block stores a 256-entry color table and translates 8-bit pixel codes into packed 24-bit RGB words for a display pipeline. A processor fills the table through two write-only registers. One register selects the entry to load. The other receives color bytes, which the block routes in turn to the red, green and blue channel of the selected entry. Once an entry's blue byte is stored, the block moves to the next entry. A whole table can therefore be streamed in after a single index write.

A 32-bit write to the color register counts as four color bytes in a row, taken from the most significant byte down. The red/green/blue rotation carries on across those bytes and across entry boundaries. Each color write also sets a sticky flag that tells the refresh logic the palette has changed. The pixel side is a separate read port with one cycle of latency.

Top module: `pal_lut_top`

## Requirements
- R1: A write to offset 0x0 loads `wr_data[7:0]` as the current entry number and makes the next color byte a red byte, even if an entry was only partly loaded.
- R2: Each color byte written to offset 0x4 goes to the channel selected by the phase, which cycles red, then green, then blue. A byte-size write (`wr_size`=0) supplies exactly one byte, taken from `wr_data[7:0]`.
- R3: Storing a blue byte advances the entry number by one, wrapping from 255 to 0, and returns the phase to red.
- R4: A word-size write (`wr_size`=1) to offset 0x4 supplies four color bytes in the order `wr_data[31:24]`, `[23:16]`, `[15:8]`, `[7:0]`. The phase rotation and the entry advance continue across these bytes exactly as for four separate byte writes.
- R5: `rd_data` reads as zero for every register.
- R6: Reset, synchronous and active low, clears all 768 color bytes, sets the entry number to 0 and the phase to red, and sets `dirty_o`.
- R7: `pix_valid_o` follows `pix_valid_i` one clock later. When `pix_valid_i` is high, `pix_rgb_o` then shows the entry selected by `pix_idx_i`, with red in bits 23:16, green in 15:8 and blue in 7:0, taken from the contents before that edge.
- R8: Any color write sets `dirty_o`, which stays set until a `dirty_clr_i` pulse clears it. A color write in the same cycle as the clear takes priority. Index writes leave the flag unchanged.
- R9: Writes to any offset other than 0x0 and 0x4 change neither the palette, the entry number, the phase, nor `dirty_o`.
- R10: While `pix_valid_i` is low, `pix_rgb_o` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register byte offset |
| wr_size | input | 1 | 0 = byte write, 1 = 32-bit write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Register read data (always zero) |
| dirty_clr_i | input | 1 | Pulse clearing the palette-changed flag |
| dirty_o | output | 1 | Palette-changed flag |
| pix_valid_i | input | 1 | Pixel lookup request |
| pix_idx_i | input | 8 | Pixel code to translate |
| pix_valid_o | output | 1 | Lookup result valid |
| pix_rgb_o | output | 24 | Looked-up color, R/G/B packed |

## Verification
The bench first goes after the places where the phase and the entry number must interact. One case rewrites the index after a lone red byte: a loader that fails to reset the phase would put the next byte in green. Another fills entry 255 and writes one more byte: a design that wraps wrongly writes to the wrong entry, or to none. Word writes are started from the red phase and, separately, from the blue phase next to the wrap point. A design that unpacks bytes least-significant first, or restarts the rotation per word, produces swapped or shifted channels that the bench detects. The bench also checks four more things:
- a clear pulse that arrives together with a color write, which must leave the flag set;
- byte writes whose upper data bits are nonzero;
- writes to other offsets, which must leave everything unchanged;
- a reset in mid-stream, which must empty the table and restart the loader at entry 0, red.

// File: rtl/pal_pkg.sv
// Package: shared constants and the color-phase type for the palette block.
// Assumes three color channels; register offsets are byte offsets on the bus.
package pal_pkg;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    localparam int unsigned NCHAN     = 3;
    localparam int unsigned OFS_INDEX = 0;
    localparam int unsigned OFS_COLOR = 4;

endpackage

// File: rtl/pal_seq.sv
// Module: pal_seq
// Decodes register writes and walks the red/green/blue phase for each color
// byte, producing up to NB byte-write slots per cycle plus the next loader
// state. Assumes wr_size=1 means NB bytes, MSB first; wr_size=0 means one
// byte in the lowest lane.
module pal_seq
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned CH_W   = 8,
    parameter int unsigned NB     = 4,
    parameter int unsigned ADDR_W = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic                       wr_size,
    input  logic [NB*CH_W-1:0]         wr_data,
    output logic [NB-1:0]              slot_en,
    output logic [NB-1:0][1:0]         slot_ph,
    output logic [NB-1:0][IDX_W-1:0]   slot_idx,
    output logic [NB-1:0][CH_W-1:0]    slot_dat,
    output logic                       col_hit,
    output logic [IDX_W-1:0]           idx_q,
    output logic [1:0]                 ph_q
);

    localparam logic [ADDR_W-1:0] A_IDX = ADDR_W'(OFS_INDEX);
    localparam logic [ADDR_W-1:0] A_COL = ADDR_W'(OFS_COLOR);

    logic             idx_hit;
    logic [IDX_W-1:0] idx_nxt;
    phase_e           ph_reg;
    phase_e           ph_nxt;

    assign ph_q = ph_reg;

    // Purpose: expand the write into byte slots and walk phase/index across them.
    always_comb begin
        phase_e           ph_w;
        logic [IDX_W-1:0] ix_w;
        idx_hit = wr_en && (wr_addr == A_IDX);
        col_hit = wr_en && (wr_addr == A_COL);
        ph_w    = ph_reg;
        ix_w    = idx_q;
        for (int k = 0; k < NB; k++) begin
            slot_en[k]  = col_hit && (wr_size || (k == 0));
            slot_dat[k] = wr_size ? wr_data[(NB-1-k)*CH_W +: CH_W]
                                  : wr_data[CH_W-1:0];
            slot_ph[k]  = ph_w;
            slot_idx[k] = ix_w;
            if (slot_en[k]) begin
                if (ph_w == PH_BLU) begin
                    ph_w = PH_RED;
                    ix_w = ix_w + 1'b1;
                end else if (ph_w == PH_RED) begin
                    ph_w = PH_GRN;
                end else begin
                    ph_w = PH_BLU;
                end
            end
        end
        if (idx_hit) begin
            idx_nxt = wr_data[IDX_W-1:0];
            ph_nxt  = PH_RED;
        end else begin
            idx_nxt = ix_w;
            ph_nxt  = ph_w;
        end
    end

    // Purpose: hold the current entry number and color phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            ph_reg <= PH_RED;
        end else begin
            idx_q  <= idx_nxt;
            ph_reg <= ph_nxt;
        end
    end

endmodule

// File: rtl/pal_bank.sv
// Module: pal_bank
// One color channel of the palette: 2**IDX_W flop entries with NB write
// ports and one asynchronous read port. Assumes no two enabled ports
// address the same entry in one cycle (guaranteed by the phase walk).
module pal_bank #(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned CH_W  = 8,
    parameter int unsigned NB    = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NB-1:0]            wen,
    input  logic [NB-1:0][IDX_W-1:0] widx,
    input  logic [NB-1:0][CH_W-1:0]  wdat,
    input  logic [IDX_W-1:0]         ridx,
    output logic [CH_W-1:0]          rdat
);

    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [CH_W-1:0] mem [DEPTH];

    // Purpose: clear on reset, otherwise apply every enabled byte slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) begin
                mem[e] <= '0;
            end
        end else begin
            for (int e = 0; e < DEPTH; e++) begin
                for (int k = 0; k < NB; k++) begin
                    if (wen[k] && (widx[k] == IDX_W'(e))) begin
                        mem[e] <= wdat[k];
                    end
                end
            end
        end
    end

    assign rdat = mem[ridx];

endmodule

// File: rtl/pal_lookup.sv
// Module: pal_lookup
// Output register of the pixel port: packs the three channel reads and
// passes the valid along with one cycle of latency. Holds the last color
// while no request is present.
module pal_lookup #(
    parameter int unsigned CH_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [CH_W-1:0]   red,
    input  logic [CH_W-1:0]   grn,
    input  logic [CH_W-1:0]   blu,
    output logic              vld_o,
    output logic [3*CH_W-1:0] rgb_o
);

    // Purpose: register valid and, on a request, the packed color.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o <= 1'b0;
            rgb_o <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                rgb_o <= {red, grn, blu};
            end
        end
    end

endmodule

// File: rtl/pal_lut_top.sv
// Module: pal_lut_top
// Palette with sequential byte loader and registered pixel lookup.
// Assumes BUS_W is a multiple of CH_W and that reads have no side effects.
module pal_lut_top
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned CH_W   = 8,
    parameter int unsigned BUS_W  = 32,
    parameter int unsigned ADDR_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic                 wr_size,
    input  logic [BUS_W-1:0]     wr_data,
    output logic [BUS_W-1:0]     rd_data,
    input  logic                 dirty_clr_i,
    output logic                 dirty_o,
    input  logic                 pix_valid_i,
    input  logic [IDX_W-1:0]     pix_idx_i,
    output logic                 pix_valid_o,
    output logic [3*CH_W-1:0]    pix_rgb_o
);

    localparam int unsigned NB = BUS_W / CH_W;

    logic [NB-1:0]              slot_en;
    logic [NB-1:0][1:0]         slot_ph;
    logic [NB-1:0][IDX_W-1:0]   slot_idx;
    logic [NB-1:0][CH_W-1:0]    slot_dat;
    logic                       col_hit;
    logic [IDX_W-1:0]           idx_cur;
    logic [1:0]                 ph_cur;
    logic [NCHAN-1:0][CH_W-1:0] chan_rd;
    logic                       dirty_q;

    assign rd_data = '0;
    assign dirty_o = dirty_q;

    pal_seq #(
        .IDX_W (IDX_W),
        .CH_W  (CH_W),
        .NB    (NB),
        .ADDR_W(ADDR_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_size (wr_size),
        .wr_data (wr_data),
        .slot_en (slot_en),
        .slot_ph (slot_ph),
        .slot_idx(slot_idx),
        .slot_dat(slot_dat),
        .col_hit (col_hit),
        .idx_q   (idx_cur),
        .ph_q    (ph_cur)
    );

    for (genvar c = 0; c < NCHAN; c++) begin : g_ch
        logic [NB-1:0] wen;
        for (genvar k = 0; k < NB; k++) begin : g_slot
            assign wen[k] = slot_en[k] && (slot_ph[k] == 2'(c));
        end
        pal_bank #(
            .IDX_W(IDX_W),
            .CH_W (CH_W),
            .NB   (NB)
        ) u_bank (
            .clk  (clk),
            .rst_n(rst_n),
            .wen  (wen),
            .widx (slot_idx),
            .wdat (slot_dat),
            .ridx (pix_idx_i),
            .rdat (chan_rd[c])
        );
    end

    pal_lookup #(
        .CH_W(CH_W)
    ) u_look (
        .clk  (clk),
        .rst_n(rst_n),
        .vld_i(pix_valid_i),
        .red  (chan_rd[PH_RED]),
        .grn  (chan_rd[PH_GRN]),
        .blu  (chan_rd[PH_BLU]),
        .vld_o(pix_valid_o),
        .rgb_o(pix_rgb_o)
    );

    // Purpose: sticky palette-changed flag; a color write beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty_q <= 1'b1;
        end else if (col_hit) begin
            dirty_q <= 1'b1;
        end else if (dirty_clr_i) begin
            dirty_q <= 1'b0;
        end
    end

endmodule

// File: rtl/pal_lut_chk.sv
// Module: pal_lut_chk
// Temporal checks on the palette loader state, the flag and the pixel port.
module pal_lut_chk #(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned CH_W   = 8,
    parameter int unsigned BUS_W  = 32,
    parameter int unsigned ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_size,
    input logic [BUS_W-1:0]  wr_data,
    input logic              dirty_clr_i,
    input logic              dirty_o,
    input logic              pix_valid_i,
    input logic              pix_valid_o,
    input logic [3*CH_W-1:0] pix_rgb_o,
    input logic [IDX_W-1:0]  idx_cur,
    input logic [1:0]        ph_cur
);

    localparam int unsigned NB = BUS_W / CH_W;
    localparam logic [ADDR_W-1:0] A_IDX = ADDR_W'(pal_pkg::OFS_INDEX);
    localparam logic [ADDR_W-1:0] A_COL = ADDR_W'(pal_pkg::OFS_COLOR);

    logic idx_wr, col_wr, oth_wr;
    assign idx_wr = wr_en && (wr_addr == A_IDX);
    assign col_wr = wr_en && (wr_addr == A_COL);
    assign oth_wr = wr_en && !idx_wr && !col_wr;

    AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (idx_cur == $past(wr_data[IDX_W-1:0])) && (ph_cur == 2'd0)); // R1
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (col_wr && !wr_size && ph_cur != 2'd2) |=> (ph_cur == $past(ph_cur) + 2'd1) && (idx_cur == $past(idx_cur))); // R2
    AST_BLUE_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (col_wr && !wr_size && ph_cur == 2'd2) |=> (ph_cur == 2'd0) && (idx_cur == $past(idx_cur) + 1'b1)); // R3
    AST_WORD_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (col_wr && wr_size) |=> (32'(ph_cur) == (32'($past(ph_cur)) + NB) % 3)
            && (idx_cur == IDX_W'(32'($past(idx_cur)) + (32'($past(ph_cur)) + NB) / 3))); // R4
    AST_PIX_VALID_ON: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_i |=> pix_valid_o); // R7
    AST_PIX_VALID_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid_i |=> !pix_valid_o); // R7
    AST_DIRTY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        col_wr |=> dirty_o); // R8
    AST_DIRTY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_clr_i && !col_wr) |=> !dirty_o); // R8
    AST_DIRTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dirty_clr_i && !col_wr) |=> $stable(dirty_o)); // R8
    AST_OTHER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        oth_wr |=> $stable(idx_cur) && $stable(ph_cur)); // R9
    AST_PIX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid_i |=> $stable(pix_rgb_o)); // R10

endmodule

bind pal_lut_top pal_lut_chk #(
    .IDX_W (IDX_W),
    .CH_W  (CH_W),
    .BUS_W (BUS_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_size    (wr_size),
    .wr_data    (wr_data),
    .dirty_clr_i(dirty_clr_i),
    .dirty_o    (dirty_o),
    .pix_valid_i(pix_valid_i),
    .pix_valid_o(pix_valid_o),
    .pix_rgb_o  (pix_rgb_o),
    .idx_cur    (idx_cur),
    .ph_cur     (ph_cur)
);

// File: tb/tb_pal_lut_top.sv
// Directed bench for pal_lut_top: one task per scenario, each checking itself.
module tb_pal_lut_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic        wr_size = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        dirty_clr_i = 1'b0;
    logic        dirty_o;
    logic        pix_valid_i = 1'b0;
    logic [7:0]  pix_idx_i = '0;
    logic        pix_valid_o;
    logic [23:0] pix_rgb_o;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pal_lut_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_size    (wr_size),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .dirty_clr_i(dirty_clr_i),
        .dirty_o    (dirty_o),
        .pix_valid_i(pix_valid_i),
        .pix_idx_i  (pix_idx_i),
        .pix_valid_o(pix_valid_o),
        .pix_rgb_o  (pix_rgb_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic sz, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_size = sz; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_size = 1'b0; wr_data = '0;
    endtask

    task automatic set_idx(input logic [7:0] i);
        bus_wr(5'h0, 1'b0, {24'h0, i});
    endtask

    task automatic put_byte(input logic [7:0] b);
        bus_wr(5'h4, 1'b0, {24'h0, b});
    endtask

    task automatic look(input string req, input logic [7:0] i, input logic [23:0] exp);
        @(negedge clk);
        pix_valid_i = 1'b1; pix_idx_i = i;
        @(negedge clk);
        pix_valid_i = 1'b0;
        check({req, " valid"}, {31'h0, pix_valid_o}, 32'h1);
        check({req, " rgb"}, {8'h0, pix_rgb_o}, {8'h0, exp});
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        dirty_clr_i = 1'b1;
        @(negedge clk);
        dirty_clr_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        check("R6 dirty after reset", {31'h0, dirty_o}, 32'h1);
        check("R7 valid idle after reset", {31'h0, pix_valid_o}, 32'h0);
        look("R6 entry 0 cleared", 8'd0, 24'h0);
        look("R6 entry 255 cleared", 8'd255, 24'h0);
        check("R5 read zero", rd_data, 32'h0);
    endtask

    task automatic t_dirty_basic();
        pulse_clear();
        check("R8 clear pulse", {31'h0, dirty_o}, 32'h0);
        set_idx(8'd5);
        check("R8 index write keeps flag", {31'h0, dirty_o}, 32'h0);
    endtask

    task automatic t_byte_seq();
        put_byte(8'h11); put_byte(8'h22); put_byte(8'h33);
        check("R8 color write sets flag", {31'h0, dirty_o}, 32'h1);
        look("R2 R7 entry 5", 8'd5, 24'h112233);
        look("R3 entry 6 untouched", 8'd6, 24'h0);
        put_byte(8'h44);
        look("R3 advance to entry 6", 8'd6, 24'h440000);
    endtask

    task automatic t_index_restart();
        set_idx(8'd10); put_byte(8'hAA);
        set_idx(8'd10); put_byte(8'hBB); put_byte(8'hCC); put_byte(8'hDD);
        look("R1 phase restarts red", 8'd10, 24'hBBCCDD);
        look("R1 entry 11 untouched", 8'd11, 24'h0);
    endtask

    task automatic t_wrap();
        set_idx(8'd255);
        put_byte(8'h01); put_byte(8'h02); put_byte(8'h03); put_byte(8'h04);
        look("R3 entry 255", 8'd255, 24'h010203);
        look("R3 wrap to entry 0", 8'd0, 24'h040000);
    endtask

    task automatic t_word();
        set_idx(8'd20);
        bus_wr(5'h4, 1'b1, 32'h10203040);
        look("R4 word msb first", 8'd20, 24'h102030);
        look("R4 fourth byte next entry", 8'd21, 24'h400000);
        bus_wr(5'h4, 1'b1, 32'h50607080);
        look("R4 word continues phase", 8'd21, 24'h405060);
        look("R4 word spills red green", 8'd22, 24'h708000);
    endtask

    task automatic t_word_wrap();
        set_idx(8'd254);
        put_byte(8'h01); put_byte(8'h02);
        bus_wr(5'h4, 1'b1, 32'hAABBCCDD);
        look("R4 word from blue", 8'd254, 24'h0102AA);
        look("R4 word whole entry", 8'd255, 24'hBBCCDD);
        put_byte(8'hEE);
        look("R3 R4 wrap after word", 8'd0, 24'hEE0000);
    endtask

    task automatic t_low_lane();
        set_idx(8'd30);
        bus_wr(5'h4, 1'b0, 32'hA5A5A55A);
        bus_wr(5'h4, 1'b0, 32'hFFFFFF66);
        bus_wr(5'h4, 1'b0, 32'h12345677);
        look("R2 byte uses low lane", 8'd30, 24'h5A6677);
        look("R2 one byte per write", 8'd31, 24'h0);
    endtask

    task automatic t_ignore();
        set_idx(8'd40); put_byte(8'h12);
        pulse_clear();
        bus_wr(5'h8, 1'b1, 32'hDEADBEEF);
        bus_wr(5'h10, 1'b0, 32'h00000099);
        bus_wr(5'h5, 1'b0, 32'h00000055);
        check("R9 flag untouched", {31'h0, dirty_o}, 32'h0);
        put_byte(8'h34); put_byte(8'h56);
        look("R9 loader state kept", 8'd40, 24'h123456);
        look("R9 no stray entry", 8'd41, 24'h0);
    endtask

    task automatic t_dirty_collide();
        pulse_clear();
        set_idx(8'd50);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'h4; wr_size = 1'b0; wr_data = 32'h01;
        dirty_clr_i = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; dirty_clr_i = 1'b0; wr_data = '0;
        check("R8 write beats clear", {31'h0, dirty_o}, 32'h1);
        pulse_clear();
        check("R8 later clear", {31'h0, dirty_o}, 32'h0);
    endtask

    task automatic t_pix_hold();
        @(negedge clk);
        pix_valid_i = 1'b1; pix_idx_i = 8'd5;
        @(negedge clk);
        check("R7 one-cycle latency", {8'h0, pix_rgb_o}, 32'h112233);
        pix_valid_i = 1'b0; pix_idx_i = 8'd10;
        @(negedge clk);
        check("R10 valid drops", {31'h0, pix_valid_o}, 32'h0);
        check("R10 color held", {8'h0, pix_rgb_o}, 32'h112233);
        @(negedge clk);
        check("R10 color still held", {8'h0, pix_rgb_o}, 32'h112233);
    endtask

    task automatic t_read_zero();
        @(negedge clk);
        wr_addr = 5'h4;
        #1;
        check("R5 color offset reads zero", rd_data, 32'h0);
        wr_addr = 5'h0;
        #1;
        check("R5 index offset reads zero", rd_data, 32'h0);
    endtask

    task automatic t_reset_mid();
        set_idx(8'd100); put_byte(8'h9A);
        pulse_clear();
        do_reset();
        check("R6 flag set by reset", {31'h0, dirty_o}, 32'h1);
        look("R6 entry 5 cleared", 8'd5, 24'h0);
        look("R6 entry 20 cleared", 8'd20, 24'h0);
        put_byte(8'h77); put_byte(8'h88); put_byte(8'h99);
        look("R6 loader back to entry 0 red", 8'd0, 24'h778899);
        look("R6 entry 100 cleared", 8'd100, 24'h0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_dirty_basic();
        t_byte_seq();
        t_index_restart();
        t_wrap();
        t_word();
        t_word_wrap();
        t_low_lane();
        t_ignore();
        t_dirty_collide();
        t_pix_hold();
        t_read_zero();
        t_reset_mid();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule